// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator with Current Sharing

This block produces the gate timing for a two-phase synchronous buck stage. A single free-running counter provides the sawtooth for phase 0. Phase 1 uses the same sawtooth delayed by half a switching period. Each phase turns its high-side gate on from the start of its own period for as long as its ramp, plus a balance offset, stays below a shared control word. A fixed ceiling caps the on-time at three quarters of the period. The low-side gate takes the rest of the period. A programmable dead time separates the two gates of a phase.

Both phases share one external current-sense channel. The block drives a select output and latches the sensed value for each phase two counts before that phase's low-side interval ends. The two held samples set the ramp offsets: the phase carrying more current sees its ramp raised, which shortens its duty, and the other phase sees its ramp lowered by the same amount. The same samples are compared against a limit input. A phase whose sample exceeds the limit is flagged, and its high side stays off until its next sample. A gate-enable input forces every gate off on the next clock edge.

Top module: `pwm2_balance_top`

## Requirements
- R1: The phase 1 ramp is the phase 0 ramp delayed by PERIOD/2 counts. With equal on-times, each rising edge of hs_o[1] comes PERIOD/2 cycles after a rising edge of hs_o[0].
- R2: For each phase p, let N = clamp(ctrl_i - off_p, 0, DUTY_MAX). When N > DEAD, hs_o[p] is high for N - DEAD cycles per period. When N <= DEAD, hs_o[p] stays low.
- R3: DUTY_MAX = PERIOD*3/4 (48 at the defaults). Any control word at or above this value gives DUTY_MAX - DEAD high-side cycles per period.
- R4: sense_sel_o is 0 (phase 0 is sensed) for ramp-0 counts PERIOD/2 to PERIOD-1, and 1 (phase 1 is sensed) otherwise. So it is high for PERIOD/2 cycles of each period. A phase's sample is taken from sense_i when that phase's own ramp count is PERIOD-2, and is held until that phase's next sample.
- R5: off_0 = (s0 - s1) >>> BAL_SHIFT, where s0 and s1 are the held samples, and off_1 = -off_0. Equal samples give no offset.
- R6: A sample strictly greater than ilim_i flags that phase until its next sample. A sample equal to the limit does not. While a phase is flagged, its high side stays off. oc_o is the OR of the two flags.
- R7: hs_o[p] and ls_o[p] are never high together. Every switch between them leaves both low for DEAD cycles.
- R8: With DEAD < N < PERIOD, ls_o[p] is high for PERIOD - N - DEAD cycles per period. With the high side off for the whole period, ls_o[p] stays high.
- R9: When gate_en_i is low at a clock edge, all four gate outputs are low after that edge.
- R10: During and after reset, with gate_en_i low, all gate outputs and oc_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | Gate enable; low forces all gates off |
| ctrl_i | input | CTRL_W | Control word compared against the ramps |
| ilim_i | input | CUR_W | Overcurrent limit |
| sense_i | input | CUR_W | Shared sensed low-side current |
| sense_sel_o | output | 1 | Sense mux select: 0 selects phase 0, 1 selects phase 1 |
| hs_o | output | 2 | High-side gate per phase |
| ls_o | output | 2 | Low-side gate per phase |
| oc_o | output | 1 | Overcurrent flag of either phase |

## Verification
The assertions check four things on every cycle: the gates of a phase are never both high, a high-side turn-on always follows a cycle with the low side off, disabling the gates takes effect on the next edge, and no high-side pulse runs longer than DUTY_MAX - DEAD. They also check that the sense select never dwells longer than half a period. Only the bench scenarios can show the balancing: the sign and size of the offsets under unequal currents, the exact on-time and off-time counts against the control word, the half-period spacing of the two phases, and the overcurrent suppression at and just above the limit.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int unsigned NPH = 2;

  function automatic int unsigned duty_ceiling(int unsigned period, int unsigned num,
                                               int unsigned den);
    return (period * num) / den;
  endfunction
endpackage

// File: rtl/pwm2_ramp.sv
module pwm2_ramp
  import pwm2_pkg::*;
#(
  parameter int unsigned PERIOD = 64,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic [NPH-1:0][CNT_W-1:0] ramp_o,
  output logic [NPH-1:0]            smp_o,
  output logic                      sel_o
);
  localparam int unsigned HALF = PERIOD / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CNT_W'(PERIOD - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    ramp_o[0] = cnt_q;
    ramp_o[1] = (cnt_q >= CNT_W'(HALF)) ? cnt_q - CNT_W'(HALF) : cnt_q + CNT_W'(HALF);
  end

  // sample two counts before each phase's low-side interval ends
  for (genvar p = 0; p < NPH; p++) begin : g_smp
    assign smp_o[p] = (ramp_o[p] == CNT_W'(PERIOD - 2));
  end

  assign sel_o = (cnt_q < CNT_W'(HALF));
endmodule

// File: rtl/pwm2_sense.sv
module pwm2_sense
  import pwm2_pkg::*;
#(
  parameter int unsigned CUR_W     = 8,
  parameter int unsigned BAL_SHIFT = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPH-1:0]          smp_i,
  input  logic [CUR_W-1:0]        sense_i,
  input  logic [CUR_W-1:0]        ilim_i,
  output logic [NPH-1:0][CUR_W:0] off_o,
  output logic [NPH-1:0]          oc_o
);
  logic [NPH-1:0][CUR_W-1:0] hold_q;
  logic signed [CUR_W:0]     diff;
  logic signed [CUR_W:0]     off0;

  for (genvar p = 0; p < NPH; p++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[p] <= '0;
        oc_o[p]   <= 1'b0;
      end else if (smp_i[p]) begin
        hold_q[p] <= sense_i;
        oc_o[p]   <= (sense_i > ilim_i);
      end
    end
  end

  always_comb begin
    diff     = $signed({1'b0, hold_q[0]}) - $signed({1'b0, hold_q[1]});
    off0     = diff >>> BAL_SHIFT;
    off_o[0] = off0;
    off_o[1] = -off0;
  end
endmodule

// File: rtl/pwm2_gate.sv
module pwm2_gate #(
  parameter int unsigned DEAD = 2,
  localparam int unsigned DT_W = (DEAD < 2) ? 1 : $clog2(DEAD)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  output logic hs_o,
  output logic ls_o
);
  logic [DT_W-1:0] dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      dt_q <= DT_W'(DEAD - 1);
    end else if (!en_i) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      dt_q <= DT_W'(DEAD - 1);
    end else if (req_i) begin
      if (ls_o) begin
        ls_o <= 1'b0;
        dt_q <= DT_W'(DEAD - 1);
      end else if (!hs_o) begin
        if (dt_q == '0) hs_o <= 1'b1;
        else dt_q <= dt_q - 1'b1;
      end
    end else begin
      if (hs_o) begin
        hs_o <= 1'b0;
        dt_q <= DT_W'(DEAD - 1);
      end else if (!ls_o) begin
        if (dt_q == '0) ls_o <= 1'b1;
        else dt_q <= dt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm2_balance_top.sv
module pwm2_balance_top
  import pwm2_pkg::*;
#(
  parameter int unsigned PERIOD    = 64,
  parameter int unsigned DUTY_NUM  = 3,
  parameter int unsigned DUTY_DEN  = 4,
  parameter int unsigned DEAD      = 2,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned CUR_W     = 8,
  parameter int unsigned BAL_SHIFT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [CUR_W-1:0]  ilim_i,
  input  logic [CUR_W-1:0]  sense_i,
  output logic              sense_sel_o,
  output logic [NPH-1:0]    hs_o,
  output logic [NPH-1:0]    ls_o,
  output logic              oc_o
);
  localparam int unsigned CNT_W    = $clog2(PERIOD);
  localparam int unsigned DUTY_MAX = duty_ceiling(PERIOD, DUTY_NUM, DUTY_DEN);
  localparam int unsigned TW       = ((CTRL_W > CUR_W) ? CTRL_W : CUR_W) + CNT_W + 2;
  localparam logic signed [TW-1:0] DMAX_S = TW'(DUTY_MAX);

  logic [NPH-1:0][CNT_W-1:0] ramp;
  logic [NPH-1:0]            smp;
  logic [NPH-1:0][CUR_W:0]   off;
  logic [NPH-1:0]            oc;

  pwm2_ramp #(.PERIOD(PERIOD)) ramp_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ramp_o(ramp),
    .smp_o (smp),
    .sel_o (sense_sel_o)
  );

  pwm2_sense #(.CUR_W(CUR_W), .BAL_SHIFT(BAL_SHIFT)) sense_i_u (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .sense_i(sense_i),
    .ilim_i (ilim_i),
    .off_o  (off),
    .oc_o   (oc)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic signed [TW-1:0] th;
    logic [CNT_W:0]       nlim;
    logic                 req;

    // offset raises or lowers the ramp: equivalent to shifting the threshold
    always_comb begin
      th = TW'(ctrl_i) - TW'($signed(off[p]));
      if (th < 0) nlim = '0;
      else if (th > DMAX_S) nlim = (CNT_W + 1)'(DUTY_MAX);
      else nlim = th[CNT_W:0];
      req = !oc[p] && ({1'b0, ramp[p]} < nlim);
    end

    pwm2_gate #(.DEAD(DEAD)) gate_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (gate_en_i),
      .req_i (req),
      .hs_o  (hs_o[p]),
      .ls_o  (ls_o[p])
    );
  end

  assign oc_o = |oc;
endmodule

// File: rtl/pwm2_balance_chk.sv
module pwm2_balance_chk
  import pwm2_pkg::*;
#(
  parameter int unsigned PERIOD   = 64,
  parameter int unsigned DUTY_MAX = 48,
  parameter int unsigned DEAD     = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           gate_en_i,
  input logic           sense_sel_o,
  input logic [NPH-1:0] hs_o,
  input logic [NPH-1:0] ls_o
);
  localparam int unsigned CW   = $clog2(PERIOD) + 1;
  localparam int unsigned HALF = PERIOD / 2;

  logic [NPH-1:0][CW-1:0] hs_run_q;
  logic [CW-1:0]          sel_run_q;
  logic                   sel_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_d_q   <= 1'b1;
      sel_run_q <= '0;
    end else begin
      sel_d_q   <= sense_sel_o;
      sel_run_q <= (sense_sel_o != sel_d_q) ? '0 : sel_run_q + 1'b1;
    end
  end

  a_r4_sel_dwell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_run_q <= CW'(HALF));

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hs_run_q[p] <= '0;
      else hs_run_q[p] <= hs_o[p] ? hs_run_q[p] + 1'b1 : '0;
    end

    a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_o[p] && ls_o[p]));
    a_r7_dead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_o[p]) |-> $past(!ls_o[p]));
    a_r9_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_en_i |=> (!hs_o[p] && !ls_o[p]));
    a_r3_on_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_o[p] |-> (hs_run_q[p] < CW'(DUTY_MAX - DEAD)));
  end
endmodule

bind pwm2_balance_top pwm2_balance_chk #(
  .PERIOD  (PERIOD),
  .DUTY_MAX(DUTY_MAX),
  .DEAD    (DEAD)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gate_en_i  (gate_en_i),
  .sense_sel_o(sense_sel_o),
  .hs_o       (hs_o),
  .ls_o       (ls_o)
);

// File: tb/pwm2_balance_top_tb_top.sv
module pwm2_balance_top_tb_top;
  localparam int PERIOD = 64;
  localparam int HALF   = 32;
  localparam int DMAX   = 48;
  localparam int DEAD   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] ctrl = '0;
  logic [7:0] ilim = 8'd200;
  logic [7:0] cur_a = '0;
  logic [7:0] cur_b = '0;
  logic [7:0] sense;
  logic       sel;
  logic [1:0] hs, ls;
  logic       oc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // external shared sense path model
  assign sense = sel ? cur_b : cur_a;

  pwm2_balance_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gate_en_i(en), .ctrl_i(ctrl), .ilim_i(ilim),
    .sense_i(sense), .sense_sel_o(sel), .hs_o(hs), .ls_o(ls), .oc_o(oc)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampn(int v);
    if (v < 0) return 0;
    if (v > DMAX) return DMAX;
    return v;
  endfunction

  function automatic int hs_exp(int n);
    return (n > DEAD) ? n - DEAD : 0;
  endfunction

  function automatic int ls_exp(int n);
    return (n > DEAD) ? PERIOD - n - DEAD : -1;
  endfunction

  // settle, then count one period of gate activity
  task automatic measure(int c, int a, int b, int lim,
                         output int h0, output int h1, output int l0, output int l1,
                         output int ov, output int sh, output int ocv);
    @(negedge clk);
    ctrl = 8'(c); cur_a = 8'(a); cur_b = 8'(b); ilim = 8'(lim);
    repeat (3 * PERIOD) @(negedge clk);
    h0 = 0; h1 = 0; l0 = 0; l1 = 0; ov = 0; sh = 0;
    ocv = oc;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      h0 += hs[0]; h1 += hs[1]; l0 += ls[0]; l1 += ls[1]; sh += sel;
      if ((hs[0] && ls[0]) || (hs[1] && ls[1])) ov++;
    end
  endtask

  task automatic t_reset();
    chk("R10 hs", hs, 0);
    chk("R10 ls", ls, 0);
    chk("R10 oc", oc, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 hs after release", hs, 0);
    chk("R10 ls after release", ls, 0);
    en = 1'b1;
  endtask

  task automatic t_balanced();
    int h0, h1, l0, l1, ov, sh, ocv;
    measure(30, 30, 30, 200, h0, h1, l0, l1, ov, sh, ocv);
    chk("R2 hs0 balanced", h0, hs_exp(30));
    chk("R5 hs1 balanced equals hs0", h1, hs_exp(30));
    chk("R8 ls0 balanced", l0, ls_exp(30));
    chk("R8 ls1 balanced", l1, ls_exp(30));
    chk("R7 no overlap", ov, 0);
    chk("R4 sel high per period", sh, HALF);
    chk("R6 no oc", ocv, 0);
  endtask

  task automatic t_imbalance(int a, int b);
    int h0, h1, l0, l1, ov, sh, ocv, off0;
    off0 = (a - b) / 2;
    measure(30, a, b, 200, h0, h1, l0, l1, ov, sh, ocv);
    chk("R5 R4 hs0 offset", h0, hs_exp(clampn(30 - off0)));
    chk("R5 R4 hs1 offset", h1, hs_exp(clampn(30 + off0)));
    chk("R8 ls0 offset", l0, ls_exp(clampn(30 - off0)));
    chk("R7 no overlap imbalance", ov, 0);
  endtask

  task automatic t_ceiling();
    int h0, h1, l0, l1, ov, sh, ocv;
    measure(200, 25, 25, 200, h0, h1, l0, l1, ov, sh, ocv);
    chk("R3 hs0 ceiling", h0, DMAX - DEAD);
    chk("R3 hs1 ceiling", h1, DMAX - DEAD);
    chk("R8 ls0 at ceiling", l0, PERIOD - DMAX - DEAD);
  endtask

  task automatic t_low_ctrl();
    int h0, h1, l0, l1, ov, sh, ocv;
    measure(0, 25, 25, 200, h0, h1, l0, l1, ov, sh, ocv);
    chk("R2 hs0 zero ctrl", h0, 0);
    chk("R8 ls0 full period", l0, PERIOD);
    measure(DEAD, 25, 25, 200, h0, h1, l0, l1, ov, sh, ocv);
    chk("R2 hs0 ctrl at dead", h0, 0);
    chk("R2 hs1 ctrl at dead", h1, 0);
  endtask

  task automatic t_interleave();
    int h0, h1, l0, l1, ov, sh, ocv;
    int t0, t1;
    logic [1:0] prev;
    measure(30, 30, 30, 200, h0, h1, l0, l1, ov, sh, ocv);
    t0 = -1; t1 = -1; prev = hs;
    for (int k = 0; k < 2 * PERIOD; k++) begin
      @(negedge clk);
      if (t0 < 0 && !prev[0] && hs[0]) t0 = k;
      else if (t0 >= 0 && t1 < 0 && !prev[1] && hs[1]) t1 = k;
      prev = hs;
    end
    chk("R1 phase spacing", t1 - t0, HALF);
  endtask

  task automatic t_overcurrent();
    int h0, h1, l0, l1, ov, sh, ocv;
    measure(30, 100, 20, 80, h0, h1, l0, l1, ov, sh, ocv);
    chk("R6 oc flag", ocv, 1);
    chk("R6 hs0 suppressed", h0, 0);
    chk("R6 ls0 held on", l0, PERIOD);
    chk("R6 R5 hs1 keeps switching", h1, hs_exp(clampn(30 + 40)));
    measure(30, 80, 80, 80, h0, h1, l0, l1, ov, sh, ocv);
    chk("R6 equal to limit no oc", ocv, 0);
    chk("R6 equal to limit hs0", h0, hs_exp(30));
  endtask

  task automatic t_enable();
    @(negedge clk);
    ctrl = 8'd30; cur_a = 8'd30; cur_b = 8'd30; ilim = 8'd200;
    repeat (2 * PERIOD + 5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 gates off next cycle", {hs, ls}, 0);
    repeat (PERIOD) @(negedge clk);
    chk("R9 gates stay off", {hs, ls}, 0);
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_balanced();
    t_imbalance(40, 20);
    t_imbalance(20, 40);
    t_ceiling();
    t_low_ctrl();
    t_interleave();
    t_overcurrent();
    t_enable();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule